// File: doc/BRIEF.md
# Sine Synthesizer with Pulse-Width Output

This block produces a sine wave as a pulse-width-modulated logic signal. An external analog lowpass filter smooths that signal into the waveform. A phase accumulator steps once per PWM period. The top bits of its phase select an entry in a sine table, and the table value, scaled to the current period length, sets the number of high clocks in the next PWM period. The same period therefore sets both the duty resolution and the synthesis sample rate. A 64-clock period at 32 MHz gives 500 kHz. A 256-clock period gives full 8-bit duty resolution at 125 kHz.

Software writes a tuning word through a load strobe and programs the period length. Neither value disturbs the period in progress. Both are taken up at the next period boundary, so a duty change never shortens or splits a pulse. A strobe marks the first clock of every period so that other logic can follow the sample rate.

Top module: `dds_sine_pwm`

## Requirements
- R1: While rst_n is low at a clock edge, pwm_out and sample_stb are low. The first period after reset lasts DEF_PERIOD (64) clocks, pwm_out stays low for all of it, and sample_stb does not pulse at its start.
- R2: sample_stb is high for exactly one clock: the first clock of each period after the first.
- R3: Each period lasts the effective period length latched at its start. The effective length is period_cfg, or 2 when period_cfg is below 2.
- R4: Within a period, pwm_out is high for the first D clocks and low for the rest. There is one contiguous pulse and no glitch.
- R5: The 32-bit phase advances by the active tuning word once per period, modulo 2^32.
- R6: The sine table has 256 entries. The entry for index i is c(i) = floor(127.5 + 127.5*sin(2*pi*i/256) + 0.5). The index is phase bits [31:24].
- R7: The on-time of period k is D = ((c + c[7]) * P) >> 8. Here c is the table entry for the phase held during period k-1, and P is the length of period k. D therefore covers 0 up to and including P.
- R8: A tune_load pulse captures tune_word. The new word first advances the phase at the next period boundary, and the period in progress keeps its on-time.
- R9: A change of period_cfg takes effect only at the next period boundary.
- R10: With a tuning word of zero, the on-time stays the same from one period to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tune_word | input | ACC_W (32) | Phase increment per period |
| tune_load | input | 1 | Capture strobe for tune_word |
| period_cfg | input | PER_W (12) | PWM period length in clocks |
| pwm_out | output | 1 | Pulse-width-modulated sine |
| sample_stb | output | 1 | High on the first clock of each period |

## Verification
Every result of this block appears at a period boundary. The on-time of a period depends on the phase held during the period before it. A tuning word or period value written during period k first shows up in period k+1, and its effect on the on-time appears one period later still. The bench drives all inputs on falling edges, right at the first clock of a period. It computes the expected length and on-time for that period before changing anything, then counts high and total clocks at falling edges until the next strobe. Every comparison is therefore made against a whole, already latched period.

// File: rtl/dds_pwm_pkg.sv
// Shared helpers for the sine PWM synthesizer.
// Assumes constant evaluation of real math at elaboration time.
package dds_pwm_pkg;

    localparam real PI_R = 3.14159265358979;

    // Returns the rounded sine sample for one table position, offset to 0..top.
    function automatic int unsigned sine_code(input int unsigned pos,
                                              input int unsigned depth,
                                              input int unsigned top);
        real half;
        real v;
        half = real'(top) / 2.0;
        v    = half + half * $sin(2.0 * PI_R * real'(pos) / real'(depth));
        return $unsigned(int'($floor(v + 0.5)));
    endfunction

endpackage

// File: rtl/dds_phase_acc.sv
// Phase accumulator with a tuning word held until the next period boundary.
// Assumes 'advance' pulses for one clock at each PWM period boundary.
module dds_phase_acc #(
    parameter int ACC_W = 32,
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune_word,
    input  logic             tune_load,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);

    logic [ACC_W-1:0] tune_pend;
    logic [ACC_W-1:0] phase;

    // Hold the most recently loaded tuning word.
    always_ff @(posedge clk) begin
        if (!rst_n)         tune_pend <= '0;
        else if (tune_load) tune_pend <= tune_word;
    end

    // Step the phase once per PWM period.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase <= '0;
        else if (advance) phase <= phase + tune_pend;
    end

    assign idx = phase[ACC_W-1 -: IDX_W];

    AST_TUNE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        tune_load |=> tune_pend == $past(tune_word)); // R8
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(phase)); // R5
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> phase == $past(phase) + $past(tune_pend)); // R5

endmodule

// File: rtl/dds_sine_rom.sv
// Registered sine lookup, filled from a function evaluated at elaboration.
// Output lags the index by one clock.
module dds_sine_rom #(
    parameter int IDX_W  = 8,
    parameter int SAMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    output logic [SAMP_W-1:0] code
);

    localparam int          DEPTH = 1 << IDX_W;
    localparam int unsigned TOP   = (1 << SAMP_W) - 1;

    logic [SAMP_W-1:0] tbl [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        localparam int unsigned VAL =
            dds_pwm_pkg::sine_code($unsigned(gi), $unsigned(DEPTH), TOP);
        assign tbl[gi] = SAMP_W'(VAL);
    end

    // Register the table entry for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) code <= '0;
        else        code <= tbl[idx];
    end

endmodule

// File: rtl/dds_pwm_timer.sv
// PWM period counter. It latches period length and on-time at each boundary
// and scales the sine sample to the new period.
// Assumes 'code' is stable for at least one clock before each boundary.
module dds_pwm_timer #(
    parameter int PER_W      = 12,
    parameter int SAMP_W     = 8,
    parameter int DEF_PERIOD = 64,
    parameter int MIN_PERIOD = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period_in,
    input  logic [SAMP_W-1:0] code,
    output logic              period_end,
    output logic              pwm_out,
    output logic              sample_stb
);

    localparam int PROD_W = SAMP_W + 1 + PER_W;

    logic [PER_W-1:0]  cnt;
    logic [PER_W-1:0]  per_cur;
    logic [PER_W-1:0]  duty_cur;
    logic [PER_W-1:0]  per_eff;
    logic [SAMP_W:0]   code_ext;
    logic [PROD_W-1:0] prod;
    logic [PER_W-1:0]  duty_nxt;
    logic              stb_q;

    // Clamp the requested period to the shortest usable length.
    assign per_eff = (period_in < PER_W'(MIN_PERIOD)) ? PER_W'(MIN_PERIOD) : period_in;

    // Scale the sample so that the top code maps to the full period.
    always_comb begin
        code_ext = {1'b0, code} + {{SAMP_W{1'b0}}, code[SAMP_W-1]};
        prod     = PROD_W'(code_ext) * PROD_W'(per_eff);
        duty_nxt = PER_W'(prod >> SAMP_W);
    end

    assign period_end = (cnt == per_cur - 1'b1);

    // Count clocks within the period and wrap at its end.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (period_end) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Latch the length and on-time of the next period at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_cur  <= PER_W'(DEF_PERIOD);
            duty_cur <= '0;
        end else if (period_end) begin
            per_cur  <= per_eff;
            duty_cur <= duty_nxt;
        end
    end

    // Flag the first clock of each new period.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= period_end;
    end

    assign sample_stb = stb_q;
    assign pwm_out    = (cnt < duty_cur);

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per_cur); // R3
    AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        per_cur >= PER_W'(MIN_PERIOD)); // R3
    AST_DUTY_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        duty_cur <= per_cur); // R7
    AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> $stable(duty_cur)); // R4
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb); // R2
    AST_STB_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> cnt == '0); // R2

endmodule

// File: rtl/dds_sine_pwm.sv
// Top level: a phase accumulator stepped per PWM period drives a sine table,
// and the table value sets the on-time of the following period.
// Assumes IDX_W <= ACC_W and that period_cfg fits PER_W.
module dds_sine_pwm #(
    parameter int ACC_W      = 32,
    parameter int IDX_W      = 8,
    parameter int SAMP_W     = 8,
    parameter int PER_W      = 12,
    parameter int DEF_PERIOD = 64,
    parameter int MIN_PERIOD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] tune_word,
    input  logic             tune_load,
    input  logic [PER_W-1:0] period_cfg,
    output logic             pwm_out,
    output logic             sample_stb
);

    logic              adv;
    logic [IDX_W-1:0]  idx;
    logic [SAMP_W-1:0] code;

    dds_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .tune_load(tune_load),
        .advance(adv), .idx(idx)
    );

    dds_sine_rom #(.IDX_W(IDX_W), .SAMP_W(SAMP_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .idx(idx), .code(code)
    );

    dds_pwm_timer #(.PER_W(PER_W), .SAMP_W(SAMP_W), .DEF_PERIOD(DEF_PERIOD),
                    .MIN_PERIOD(MIN_PERIOD)) u_timer (
        .clk(clk), .rst_n(rst_n), .period_in(period_cfg), .code(code),
        .period_end(adv), .pwm_out(pwm_out), .sample_stb(sample_stb)
    );

endmodule

// File: tb/dds_sine_pwm_bench.sv
// Directed bench: each task drives one scenario and checks every period it spans.
module dds_sine_pwm_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tune_word = '0;
    logic        tune_load = 1'b0;
    logic [11:0] period_cfg = 12'd64;
    wire         pwm_out;
    wire         sample_stb;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    logic [31:0] m_phase = '0;
    logic [31:0] m_tune = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dds_sine_pwm u_dds_sine_pwm (
        .clk(clk), .rst_n(rst_n), .tune_word(tune_word), .tune_load(tune_load),
        .period_cfg(period_cfg), .pwm_out(pwm_out), .sample_stb(sample_stb)
    );

    function automatic int ref_code(input int i);
        real x;
        x = 127.5 + 127.5 * $sin(2.0 * 3.14159265358979 * i / 256.0);
        return int'($floor(x + 0.5));
    endfunction

    function automatic int ref_duty(input int c, input int p);
        return ((c + ((c >= 128) ? 1 : 0)) * p) / 256;
    endfunction

    function automatic int eff_per(input int p);
        return (p < 2) ? 2 : p;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Count one period from the current falling edge up to the next strobe.
    task automatic measure(output int len, output int hi, output bit clean);
        bit low_seen;
        len = 0; hi = 0; clean = 1'b1; low_seen = 1'b0;
        do begin
            if (pwm_out) begin
                hi++;
                if (low_seen) clean = 1'b0;
            end else begin
                low_seen = 1'b1;
            end
            len++;
            @(negedge clk);
            tune_load = 1'b0;
        end while (!sample_stb && len < 5000);
    endtask

    // Check one period. Inputs may change at its first clock.
    task automatic step(input int new_per, input bit do_load, input logic [31:0] tw,
                        input string req, output int hi_out);
        int ep, ed, len, hi;
        bit clean;
        chk(sample_stb, {"R2 ", req}, "strobe at period start", int'(sample_stb), 1);
        ep = eff_per(int'(period_cfg));
        ed = ref_duty(ref_code(int'(m_phase[31:24])), ep);
        m_phase = m_phase + m_tune;
        if (do_load) begin
            tune_word = tw; tune_load = 1'b1; m_tune = tw;
        end
        if (new_per >= 0) period_cfg = 12'(new_per);
        measure(len, hi, clean);
        chk(len == ep, {"R3 R2 ", req}, "period length", len, ep);
        chk(hi == ed, {"R6 R7 R5 ", req}, "on-time", hi, ed);
        chk(clean, {"R4 ", req}, "single pulse", int'(clean), 1);
        hi_out = hi;
    endtask

    task automatic t_reset();
        int len, hi;
        bit clean;
        repeat (4) @(negedge clk);
        chk(!pwm_out, "R1", "pwm in reset", int'(pwm_out), 0);
        chk(!sample_stb, "R1", "strobe in reset", int'(sample_stb), 0);
        rst_n = 1'b1;
        measure(len, hi, clean);
        chk(len == 64, "R1", "first period length", len, 64);
        chk(hi == 0, "R1", "first period on-time", hi, 0);
    endtask

    task automatic t_zero_tune();
        int h, first;
        step(-1, 1'b0, '0, "R10", first);
        for (int i = 0; i < 3; i++) begin
            step(-1, 1'b0, '0, "R10", h);
            chk(h == first, "R10", "constant on-time", h, first);
        end
        chk(first == 32, "R10", "mid-scale on-time", first, 32);
    endtask

    task automatic t_sweep();
        int h, hmax, hmin;
        step(-1, 1'b1, 32'h0400_0000, "R8", h);
        chk(h == 32, "R8", "period in progress unchanged", h, 32);
        hmax = 0; hmin = 1000;
        for (int i = 0; i < 72; i++) begin
            step(-1, 1'b0, '0, "R5", h);
            if (h > hmax) hmax = h;
            if (h < hmin) hmin = h;
        end
        chk(hmax == 64, "R7", "full-period on-time reached", hmax, 64);
        chk(hmin == 0, "R7", "zero on-time reached", hmin, 0);
    endtask

    task automatic t_period_change();
        int h;
        step(256, 1'b0, '0, "R9", h);
        for (int i = 0; i < 5; i++) step(-1, 1'b0, '0, "R9", h);
    endtask

    task automatic t_clamp_and_wrap();
        int h;
        step(1, 1'b0, '0, "R3", h);
        for (int i = 0; i < 3; i++) step(-1, 1'b0, '0, "R3", h);
        step(0, 1'b0, '0, "R3", h);
        step(-1, 1'b0, '0, "R3", h);
        step(-1, 1'b0, '0, "R3", h);
        step(100, 1'b1, 32'hE000_0001, "R8", h);
        for (int i = 0; i < 16; i++) step(-1, 1'b0, '0, "R5", h);
    endtask

    initial begin
        t_reset();
        t_zero_tune();
        t_sweep();
        t_period_change();
        t_clamp_and_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule